// File: doc/BRIEF.md
# Paletted Scanline Prefetch Engine

This block fills a local line buffer ahead of the display beam. When the pixel side advances to a new row, the engine reads that row's 80 words of 8-bit indexed pixels from video memory. It reads one word at a time over a request/valid port. Every returned word carries four indices. Each index goes through its own copy of a 256-entry, 24-bit color table, so one word is converted in a single cycle. The four colors are stored together, one per line bank, and each bank holds every fourth pixel of the line.

A CPU-side write port loads the color table. Each write goes to all four copies at once, so they always hold the same colors. The display side reads the line back by pixel column. The low two column bits pick the bank, and the upper bits pick the entry within that bank.

The row-change signal is a level that toggles in the slower pixel domain. The engine brings it into the system clock through two flops and treats either edge as a start. A start that arrives during a fetch abandons the current line and begins again at word 0 of the new row. A read that is still in flight when this happens is discarded on its return.

Top module: `scanline_prefetch`

## Requirements
- R1: After reset, `busy_o` and `mem_req_o` are both low.
- R2: A change of level on `row_tgl_i` raises `mem_req_o` in the third clock cycle after it is applied, and `busy_o` rises with it. The first read address is `FRAME_BASE + row * 80`, where `row` is the value held on `row_num_i`.
- R3: The reads of a line go to consecutive word addresses, starting at the line start. Only one read is ever outstanding, and a new request waits until `mem_rvalid_i` has returned the previous word.
- R4: Pixel column `4k+j` of a line (j = 0..3) is the palette color of byte j of word k, where byte j is bits `8j+7:8j` of `mem_rdata_i`. `rd_rgb_o` shows that column's color one cycle after the column is applied on `rd_col_i`.
- R5: A palette write through `pal_we_i` takes effect in all four byte lanes, so the same index gives the same color whatever its position in the word.
- R6: A complete line issues exactly 80 reads. `busy_o` stays high until the color of the 80th word has been stored and then falls.
- R7: A row change that arrives during a fetch restarts the fetch at word 0 of the new row. Any read already in flight is discarded, and the finished line holds only the new row's colors.
- R8: The engine accepts any read latency of one cycle or more, and it acts only on the cycle in which `mem_rvalid_i` is high.
- R9: While idle, the engine issues no read requests.
- R10: Stored line colors do not change when the palette is rewritten afterwards. Only a later fetch uses the new colors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| row_tgl_i | input | 1 | Toggles once per row change in the pixel domain |
| row_num_i | input | ROW_W | Row to fetch; held steady around each toggle |
| pal_we_i | input | 1 | Palette write strobe |
| pal_addr_i | input | PAL_AW | Palette entry written |
| pal_data_i | input | COLOR_W | 24-bit color written |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | ADDR_W | Word address of the request |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 4*PAL_AW | Returned word of four indices |
| busy_o | output | 1 | High while a line is being fetched |
| rd_col_i | input | COL_W | Display column to read back |
| rd_rgb_o | output | COLOR_W | Color of the requested column, one cycle later |

## Verification
The assertions assume that video memory answers each request with exactly one `mem_rvalid_i` pulse, at least one cycle later, and never raises valid without a request in flight. They also assume that `row_num_i` is stable when the synchronized toggle arrives. The bench's memory model returns data for one recorded request at a time after a programmable delay. The bench sets the row two cycles before each toggle and writes the palette only while the engine is idle, so both assumptions hold throughout the run.

// File: rtl/spf_pkg.sv
package spf_pkg;

  localparam int LANES = 4;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_ISSUE,
    FS_WAIT
  } fetch_st_e;

  // word address of the first word of a row
  function automatic logic [31:0] line_start(input logic [31:0] base,
                                             input logic [31:0] row,
                                             input logic [31:0] words);
    return base + row * words;
  endfunction

  // bank that holds a given pixel column
  function automatic logic [1:0] col_lane(input logic [31:0] col);
    return col[1:0];
  endfunction

endpackage

// File: rtl/row_sync.sv
module row_sync #(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tgl_a_i,
  input  logic [ROW_W-1:0] row_a_i,
  output logic             evt_o,
  output logic [ROW_W-1:0] row_o
);

  logic             s1_q, s2_q, s3_q;
  logic [ROW_W-1:0] r1_q, r2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
      r1_q <= '0;
      r2_q <= '0;
    end else begin
      s1_q <= tgl_a_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
      r1_q <= row_a_i;
      r2_q <= r1_q;
    end
  end

  // either edge of the synchronized toggle is one row change
  assign evt_o = s2_q ^ s3_q;
  assign row_o = r2_q;

endmodule

// File: rtl/clut_ram.sv
module clut_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int DW    = 24
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end

endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl #(
  parameter int                ADDR_W = 20,
  parameter int                ROW_W  = 9,
  parameter int                WORDS  = 80,
  parameter logic [ADDR_W-1:0] BASE   = '0,
  localparam int               IW     = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ROW_W-1:0]  row_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  output logic              accept_o,
  output logic              bank_we_o,
  output logic [IW-1:0]     bank_idx_o,
  output logic              last_wr_o,
  output logic              busy_o
);
  import spf_pkg::*;

  localparam logic [IW-1:0] LAST = IW'(WORDS - 1);

  fetch_st_e         st_q;
  logic [IW-1:0]     wcnt_q;
  logic [ADDR_W-1:0] base_q;
  logic              drop_q;
  logic              lk_vld_q;
  logic [IW-1:0]     lk_idx_q;
  logic              busy_q;
  logic              in_flight;

  assign mem_req_o  = (st_q == FS_ISSUE);
  assign mem_addr_o = base_q + ADDR_W'(wcnt_q);
  assign accept_o   = (st_q == FS_WAIT) && mem_rvalid_i && !drop_q && !start_i;
  assign bank_we_o  = lk_vld_q;
  assign bank_idx_o = lk_idx_q;
  assign last_wr_o  = lk_vld_q && (lk_idx_q == LAST);
  assign busy_o     = busy_q;
  // a read is pending past this cycle if it is being issued now or not yet returned
  assign in_flight  = (st_q == FS_ISSUE) || ((st_q == FS_WAIT) && !mem_rvalid_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= FS_IDLE;
      wcnt_q   <= '0;
      base_q   <= '0;
      drop_q   <= 1'b0;
      lk_vld_q <= 1'b0;
      lk_idx_q <= '0;
      busy_q   <= 1'b0;
    end else begin
      lk_vld_q <= accept_o;
      if (accept_o) lk_idx_q <= wcnt_q;
      if (last_wr_o) busy_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        wcnt_q <= '0;
        base_q <= ADDR_W'(line_start(32'(BASE), 32'(row_i), 32'(WORDS)));
        if (in_flight) begin
          drop_q <= 1'b1;
          st_q   <= FS_WAIT;
        end else begin
          drop_q <= 1'b0;
          st_q   <= FS_ISSUE;
        end
      end else begin
        case (st_q)
          FS_ISSUE: st_q <= FS_WAIT;
          FS_WAIT: begin
            if (mem_rvalid_i) begin
              if (drop_q) begin
                drop_q <= 1'b0;
                st_q   <= FS_ISSUE;
              end else if (wcnt_q == LAST) begin
                st_q <= FS_IDLE;
              end else begin
                wcnt_q <= wcnt_q + 1'b1;
                st_q   <= FS_ISSUE;
              end
            end
          end
          default: st_q <= FS_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/scanline_prefetch.sv
module scanline_prefetch #(
  parameter int                ADDR_W     = 20,
  parameter logic [ADDR_W-1:0] FRAME_BASE = 20'h01000,
  parameter int                LINE_WORDS = 80,
  parameter int                ROW_W      = 9,
  parameter int                PAL_AW     = 8,
  parameter int                COLOR_W    = 24,
  localparam int               MEM_DW     = spf_pkg::LANES * PAL_AW,
  localparam int               WIDX_W     = $clog2(LINE_WORDS),
  localparam int               COL_W      = WIDX_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               row_tgl_i,
  input  logic [ROW_W-1:0]   row_num_i,
  input  logic               pal_we_i,
  input  logic [PAL_AW-1:0]  pal_addr_i,
  input  logic [COLOR_W-1:0] pal_data_i,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [MEM_DW-1:0]  mem_rdata_i,
  output logic               busy_o,
  input  logic [COL_W-1:0]   rd_col_i,
  output logic [COLOR_W-1:0] rd_rgb_o
);
  import spf_pkg::*;

  // named internal events, observed by the bound checker
  logic               row_evt;
  logic [ROW_W-1:0]   row_val;
  logic               accept;
  logic               bank_we;
  logic [WIDX_W-1:0]  bank_idx;
  logic               last_wr;

  logic [COLOR_W-1:0] lut_rgb [LANES];
  logic [COLOR_W-1:0] bank_q  [LANES];
  logic [1:0]         rd_lane_q;
  logic [WIDX_W-1:0]  rd_word;

  row_sync #(.ROW_W(ROW_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .tgl_a_i (row_tgl_i),
    .row_a_i (row_num_i),
    .evt_o   (row_evt),
    .row_o   (row_val)
  );

  fetch_ctrl #(
    .ADDR_W (ADDR_W),
    .ROW_W  (ROW_W),
    .WORDS  (LINE_WORDS),
    .BASE   (FRAME_BASE)
  ) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (row_evt),
    .row_i        (row_val),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .accept_o     (accept),
    .bank_we_o    (bank_we),
    .bank_idx_o   (bank_idx),
    .last_wr_o    (last_wr),
    .busy_o       (busy_o)
  );

  assign rd_word = rd_col_i[COL_W-1:2];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // palette copy for byte lane g; every copy takes every CPU write
    clut_ram #(.DEPTH(1 << PAL_AW), .AW(PAL_AW), .DW(COLOR_W)) u_pal (
      .clk     (clk),
      .we_i    (pal_we_i),
      .waddr_i (pal_addr_i),
      .wdata_i (pal_data_i),
      .re_i    (accept),
      .raddr_i (mem_rdata_i[g*PAL_AW +: PAL_AW]),
      .rdata_o (lut_rgb[g])
    );
    // line bank g holds columns g, g+4, g+8, ...
    clut_ram #(.DEPTH(LINE_WORDS), .AW(WIDX_W), .DW(COLOR_W)) u_bank (
      .clk     (clk),
      .we_i    (bank_we),
      .waddr_i (bank_idx),
      .wdata_i (lut_rgb[g]),
      .re_i    (1'b1),
      .raddr_i (rd_word),
      .rdata_o (bank_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_lane_q <= '0;
    else        rd_lane_q <= col_lane(32'(rd_col_i));
  end

  assign rd_rgb_o = bank_q[rd_lane_q];

endmodule

// File: rtl/spf_checker.sv
module spf_checker (
  input logic clk,
  input logic rst_n,
  input logic row_evt,
  input logic busy,
  input logic mem_req,
  input logic mem_rvalid,
  input logic bank_we,
  input logic last_wr
);

  logic out_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          out_q <= 1'b0;
    else if (mem_req)    out_q <= 1'b1;
    else if (mem_rvalid) out_q <= 1'b0;
  end

  // R3: a request only when nothing is outstanding
  p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !out_q);

  // R8: valid only answers a request in flight (environment rule)
  p_rvalid_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> out_q);

  // R9: no request outside a fetch
  p_req_needs_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R2: a row change starts a fetch
  p_start_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    row_evt |=> busy);

  // R6: bank writes happen only inside a fetch
  p_write_in_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |-> busy);

  // R6: busy ends only after the last word is stored
  p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(last_wr));

endmodule

bind scanline_prefetch spf_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .row_evt    (row_evt),
  .busy       (busy_o),
  .mem_req    (mem_req_o),
  .mem_rvalid (mem_rvalid_i),
  .bank_we    (bank_we),
  .last_wr    (last_wr)
);

// File: tb/scanline_prefetch_tb_top.sv
module scanline_prefetch_tb_top;

  localparam logic [19:0] BASE = 20'h01000;
  localparam int WORDS = 80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        row_tgl_i = 1'b0;
  logic [8:0]  row_num_i = '0;
  logic        pal_we_i = 1'b0;
  logic [7:0]  pal_addr_i = '0;
  logic [23:0] pal_data_i = '0;
  logic        mem_req_o;
  logic [19:0] mem_addr_o;
  logic        mem_rvalid_i;
  logic [31:0] mem_rdata_i;
  logic        busy_o;
  logic [8:0]  rd_col_i = '0;
  logic [23:0] rd_rgb_o;

  always #10 clk = ~clk;

  scanline_prefetch dut_i (
    .clk(clk), .rst_n(rst_n), .row_tgl_i(row_tgl_i), .row_num_i(row_num_i),
    .pal_we_i(pal_we_i), .pal_addr_i(pal_addr_i), .pal_data_i(pal_data_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .rd_col_i(rd_col_i), .rd_rgb_o(rd_rgb_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [23:0] pal_m [256];
  logic [23:0] exp_q [$];
  logic        rd_act = 1'b0;

  // memory model state
  int          lat_cfg = 1;
  int          req_count = 0;
  int          first_cyc = -1;
  bit          chk_addr = 1'b0;
  logic [19:0] exp_addr = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mdata(input logic [19:0] a);
    logic [31:0] x;
    x = {12'h0, a};
    return (x * 32'h9E3779B1) ^ {x[15:0], x[19:4]};
  endfunction

  function automatic logic [23:0] pal_a(input int i);
    return {8'(i * 3 + 7), 8'(~i), 8'(i ^ 8'h5a)};
  endfunction

  function automatic logic [23:0] pal_b(input int i);
    return {8'(i ^ 8'hc3), 8'(i * 5), 8'(255 - i)};
  endfunction

  function automatic logic [23:0] exp_pix(input int row, input int col);
    logic [31:0] w;
    w = mdata(20'(BASE + row * WORDS + col / 4));
    return pal_m[8'(w >> (8 * (col % 4)))];
  endfunction

  // video memory: one request recorded at a time, answered after lat_cfg cycles
  initial begin : mem_model
    bit          pend;
    int          cnt;
    logic [19:0] paddr;
    pend = 0; cnt = 0; paddr = '0;
    mem_rvalid_i = 1'b0;
    mem_rdata_i = '0;
    forever begin
      @(negedge clk);
      mem_rvalid_i = 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          mem_rvalid_i = 1'b1;
          mem_rdata_i = mdata(paddr);
          pend = 0;
        end else cnt--;
      end
      if (mem_req_o) begin
        req_count++;
        if (first_cyc < 0) first_cyc = cyc;
        if (chk_addr) begin
          chk(mem_addr_o == exp_addr, "R3 address", 32'(mem_addr_o), 32'(exp_addr));
          exp_addr++;
        end
        pend = 1;
        paddr = mem_addr_o;
        cnt = lat_cfg - 1;
      end
    end
  end

  // scoreboard monitor: compares one cycle after each column is applied
  initial begin : monitor
    forever begin
      bit act_d;
      @(posedge clk);
      act_d = rd_act;
      #1;
      if (act_d) begin
        logic [23:0] e;
        e = exp_q.pop_front();
        chk(rd_rgb_o == e, "R4 pixel", 32'(rd_rgb_o), 32'(e));
      end
    end
  end

  task automatic pal_write(input int i, input logic [23:0] v);
    @(negedge clk);
    pal_we_i = 1'b1; pal_addr_i = 8'(i); pal_data_i = v;
    @(negedge clk);
    pal_we_i = 1'b0;
  endtask

  task automatic toggle_row(input int row);
    @(negedge clk); row_num_i = 9'(row);
    @(negedge clk);
    @(negedge clk); row_tgl_i = ~row_tgl_i;
  endtask

  task automatic wait_idle(input string req);
    bit done;
    done = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!busy_o) begin done = 1; break; end
    end
    chk(done, req, 32'(busy_o), 0);
  endtask

  task automatic fetch_line(input int row, input int lat);
    int tcyc;
    lat_cfg = lat;
    exp_addr = 20'(BASE + row * WORDS);
    chk_addr = 1'b1;
    req_count = 0;
    first_cyc = -1;
    toggle_row(row);
    tcyc = cyc;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b1, "R2 busy rise", 32'(busy_o), 1);
    wait_idle("R6 busy fall");
    chk(first_cyc - tcyc == 3, "R2 start delay", 32'(first_cyc - tcyc), 3);
    chk(req_count == WORDS, "R6 read count", 32'(req_count), WORDS);
    chk_addr = 1'b0;
  endtask

  task automatic read_line(input int row);
    for (int c = 0; c < WORDS * 4; c++) begin
      @(negedge clk);
      rd_col_i = 9'(c);
      rd_act = 1'b1;
      exp_q.push_back(exp_pix(row, c));
    end
    @(negedge clk);
    rd_act = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_all();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    finish_all();
  end

  initial begin : driver
    int rc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(busy_o == 1'b0, "R1 busy", 32'(busy_o), 0);
    chk(mem_req_o == 1'b0, "R1 req", 32'(mem_req_o), 0);

    for (int i = 0; i < 256; i++) begin
      pal_m[i] = pal_a(i);
      pal_write(i, pal_a(i));
    end

    // R2 R3 R4 R6 R8: lines at several latencies
    fetch_line(5, 1);
    read_line(5);
    fetch_line(239, 3);
    read_line(239);
    fetch_line(0, 6);
    read_line(0);

    // R9: idle means no requests
    rc = req_count;
    repeat (30) @(negedge clk);
    chk(req_count == rc, "R9 idle requests", 32'(req_count), 32'(rc));

    // R10: palette rewrite leaves stored line intact
    for (int i = 0; i < 256; i++) pal_write(i, pal_b(i));
    read_line(0);

    // R5: new palette seen in every lane after refetch
    for (int i = 0; i < 256; i++) pal_m[i] = pal_b(i);
    fetch_line(77, 2);
    read_line(77);

    // R7: restart mid-line, short latency
    lat_cfg = 2;
    toggle_row(10);
    repeat (40) @(negedge clk);
    toggle_row(20);
    wait_idle("R7 busy fall");
    read_line(20);

    // R7: restart while a long read is in flight
    lat_cfg = 7;
    toggle_row(30);
    repeat (25) @(negedge clk);
    toggle_row(31);
    wait_idle("R7 busy fall");
    read_line(31);

    finish_all();
  end

endmodule